// File: doc/BRIEF.md
# Dual DMA Timeout Watchdog

This block watches a source DMA engine for two kinds of stall. One timer runs while the engine offers data on its output stream and the consumer holds it back. The other timer runs while read commands to memory are still waiting for their last data beat. Both timers share one programmable limit and one prescaled time base. A timer that reaches the limit raises a sticky timeout flag and stops.

The limit is a 12-bit value. A timer expires after (limit + 1) prescaler periods. The all-ones limit is reserved: it clears both timers and both flags for as long as it is applied. An explicit clear input does the same for one cycle. Each timer has its own pause input that freezes it in place. A global enable gates all counting.

Top module: `dma_timeout_watchdog`

## Requirements
- R1: After reset both timeout flags are low.
- R2: The prescaler raises one tick every PRESCALE_DIV enabled clock cycles, counting from 0 when the enable rises. The first tick falls on the PRESCALE_DIV-th edge. Timers advance only on ticks. A running timer sets its flag on the (limit + 1)-th tick, so a limit of 0 expires after one period.
- R3: The stream timer runs while strm_valid is 1 and strm_ready is 0. It returns to zero on any cycle where that backpressure condition is absent.
- R4: The memory timer runs while rd_outstanding is 1. It holds when rd_outstanding is 0, and it returns to zero on any cycle where rd_last is 1.
- R5: An expired timer stops and keeps its flag high until a clear, whatever the stream and memory inputs do.
- R6: While tmo_limit is all ones (0xFFF), both timers and both flags are cleared, and neither flag can rise.
- R7: A cycle with flag_clr at 1 clears both timers and both flags.
- R8: hold_strm at 1 freezes the stream timer, and hold_mem at 1 freezes the memory timer. A frozen timer neither advances nor restarts. Each pause affects only its own timer.
- R9: While tmo_en is 0, no timer advances and the prescaler returns to its start.
- R10: The two timers are independent. Each flag reflects only its own run condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmo_en | input | 1 | Global enable for counting |
| tmo_limit | input | LIMIT_W | Shared limit; all ones means clear |
| strm_valid | input | 1 | Output stream data offered |
| strm_ready | input | 1 | Output stream consumer ready |
| rd_outstanding | input | 1 | Memory reads still pending |
| rd_last | input | 1 | Last read beat sampled |
| hold_strm | input | 1 | Freeze stream timer |
| hold_mem | input | 1 | Freeze memory timer |
| flag_clr | input | 1 | Clear both timers and flags |
| strm_timeout | output | 1 | Sticky stream stall flag |
| mem_timeout | output | 1 | Sticky memory stall flag |

## Verification
On every cycle the assertions check several rules. A raised flag stays up until a clear. Any clear, from the input or from the reserved limit, drops the flag on the next cycle. A paused or disabled timer keeps its count. A flag can rise only on a prescaler tick, and ticks are never back to back. The bench scenarios are needed for the rest. They show the exact expiry edge for a given limit, the restart of the stream timer when backpressure drops, the restart of the memory timer on a last beat, and the later expiry caused by a pause. They also show that the two timers do not affect each other.

// File: rtl/dtw_pkg.sv
package dtw_pkg;
   typedef enum logic [0:0] {
      CH_STRM = 1'b0,
      CH_MEM  = 1'b1
   } dtw_chan_e;

   localparam int unsigned NUM_CH = 2;

   typedef struct packed {
      logic run;
      logic restart;
      logic pause;
   } dtw_ctl_t;
endpackage

// File: rtl/dtw_prescaler.sv
module dtw_prescaler #(
   parameter int unsigned DIV = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   if (DIV < 1) begin : g_bad_div
      $error("dtw_prescaler: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_direct
      assign tick = en;
   end else begin : g_count
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] phase_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            phase_q <= '0;
         end else if (!en) begin
            phase_q <= '0;
         end else if (phase_q == LAST) begin
            phase_q <= '0;
         end else begin
            phase_q <= phase_q + 1'b1;
         end
      end

      assign tick = en && (phase_q == LAST);

      // R2
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end
endmodule

// File: rtl/dtw_timer.sv
module dtw_timer #(
   parameter int unsigned LIMIT_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               tick,
   input  logic               run,
   input  logic               restart,
   input  logic               pause,
   input  logic               clr,
   input  logic [LIMIT_W-1:0] limit,
   output logic               expired
);
   logic [LIMIT_W-1:0] cnt_q;
   logic               flag_q;
   logic               step;
   logic               at_limit;

   assign step     = en && tick && run;
   assign at_limit = (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else if (clr) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else if (flag_q || pause) begin
         cnt_q  <= cnt_q;
      end else if (restart) begin
         cnt_q  <= '0;
      end else if (step) begin
         if (at_limit) begin
            flag_q <= 1'b1;
         end else begin
            cnt_q  <= cnt_q + 1'b1;
         end
      end
   end

   assign expired = flag_q;

   // R5
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !clr) |=> expired);
   // R6
   clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !expired);
   // R8
   pause_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pause && !clr) |=> $stable(cnt_q));
   // R9
   disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !restart && !clr) |=> $stable(cnt_q));
   // R2
   rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(expired) |-> $past(tick));
endmodule

// File: rtl/dma_timeout_watchdog.sv
module dma_timeout_watchdog #(
   parameter int unsigned LIMIT_W      = 12,
   parameter int unsigned PRESCALE_DIV = 4096
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tmo_en,
   input  logic [LIMIT_W-1:0] tmo_limit,
   input  logic               strm_valid,
   input  logic               strm_ready,
   input  logic               rd_outstanding,
   input  logic               rd_last,
   input  logic               hold_strm,
   input  logic               hold_mem,
   input  logic               flag_clr,
   output logic               strm_timeout,
   output logic               mem_timeout
);
   import dtw_pkg::*;

   if (LIMIT_W < 2) begin : g_bad_width
      $error("dma_timeout_watchdog: LIMIT_W must be at least 2");
   end

   localparam logic [LIMIT_W-1:0] CLR_CODE = '1;

   logic                  tick;
   logic                  clr_all;
   dtw_ctl_t [NUM_CH-1:0] ctl;
   logic     [NUM_CH-1:0] expired;

   assign clr_all = flag_clr || (tmo_limit == CLR_CODE);

   always_comb begin
      ctl[CH_STRM].run     = strm_valid && !strm_ready;
      ctl[CH_STRM].restart = !(strm_valid && !strm_ready);
      ctl[CH_STRM].pause   = hold_strm;
      ctl[CH_MEM].run      = rd_outstanding;
      ctl[CH_MEM].restart  = rd_last;
      ctl[CH_MEM].pause    = hold_mem;
   end

   dtw_prescaler #(.DIV(PRESCALE_DIV)) u_presc (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (tmo_en),
      .tick (tick)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_timer
      dtw_timer #(.LIMIT_W(LIMIT_W)) u_timer (
         .clk    (clk),
         .rst_n  (rst_n),
         .en     (tmo_en),
         .tick   (tick),
         .run    (ctl[ch].run),
         .restart(ctl[ch].restart),
         .pause  (ctl[ch].pause),
         .clr    (clr_all),
         .limit  (tmo_limit),
         .expired(expired[ch])
      );
   end

   assign strm_timeout = expired[CH_STRM];
   assign mem_timeout  = expired[CH_MEM];

   // R6
   reserved_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_limit == CLR_CODE) |=> !(strm_timeout || mem_timeout));
endmodule

// File: tb/dma_timeout_watchdog_bench.sv
module dma_timeout_watchdog_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DIV = 4;
   localparam int LW = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic [LW-1:0] limit = '0;
   logic valid = 1'b0, ready = 1'b0, outst = 1'b0, last = 1'b0;
   logic hs = 1'b0, hm = 1'b0, clr = 1'b0;
   logic s_to, m_to;
   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_timeout_watchdog #(.LIMIT_W(LW), .PRESCALE_DIV(DIV)) u_dma_timeout_watchdog (
      .clk(clk), .rst_n(rst_n), .tmo_en(en), .tmo_limit(limit),
      .strm_valid(valid), .strm_ready(ready), .rd_outstanding(outst),
      .rd_last(last), .hold_strm(hs), .hold_mem(hm), .flag_clr(clr),
      .strm_timeout(s_to), .mem_timeout(m_to));

   // vector: limit[23:12] bp[11] outst[10] cycles[9:2] exp_strm[1] exp_mem[0]
   localparam logic [23:0] VEC [8] = '{
      {12'd0, 1'b1, 1'b1, 8'd3,  1'b0, 1'b0},
      {12'd0, 1'b1, 1'b1, 8'd4,  1'b1, 1'b1},
      {12'd2, 1'b1, 1'b0, 8'd12, 1'b1, 1'b0},
      {12'd2, 1'b0, 1'b1, 8'd11, 1'b0, 1'b0},
      {12'd2, 1'b0, 1'b1, 8'd12, 1'b0, 1'b1},
      {12'd1, 1'b0, 1'b0, 8'd40, 1'b0, 1'b0},
      {12'd5, 1'b1, 1'b1, 8'd23, 1'b0, 1'b0},
      {12'd5, 1'b1, 1'b1, 8'd24, 1'b1, 1'b1}
   };

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic prep(input logic [LW-1:0] lim, input logic bp, input logic out);
      @(negedge clk);
      en = 1'b0; clr = 1'b1; valid = 1'b0; ready = 1'b0; outst = 1'b0;
      last = 1'b0; hs = 1'b0; hm = 1'b0; limit = lim;
      @(negedge clk);
      clr = 1'b0; en = 1'b1; valid = 1'b1; ready = !bp; outst = out;
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 3);
      @(negedge clk);
      check("R1 strm reset", s_to, 1'b0);
      check("R1 mem reset", m_to, 1'b0);
      rst_n = 1'b1;

      // R2 R3 R4 R10 table
      for (int i = 0; i < 8; i++) begin
         prep(VEC[i][23:12], VEC[i][11], VEC[i][10]);
         edges(int'(VEC[i][9:2]));
         check($sformatf("R2/R10 vec%0d strm", i), s_to, VEC[i][1]);
         check($sformatf("R2/R10 vec%0d mem", i), m_to, VEC[i][0]);
      end

      // R5 sticky after expiry
      prep(12'd0, 1'b1, 1'b1);
      edges(4);
      ready = 1'b1; outst = 1'b0; last = 1'b1;
      edges(10);
      check("R5 strm sticky", s_to, 1'b1);
      check("R5 mem sticky", m_to, 1'b1);
      // R7 explicit clear
      clr = 1'b1;
      edges(1);
      clr = 1'b0;
      check("R7 strm clr", s_to, 1'b0);
      check("R7 mem clr", m_to, 1'b0);

      // R6 reserved limit clears flags
      prep(12'd0, 1'b1, 1'b1);
      edges(4);
      limit = 12'hFFF;
      edges(1);
      check("R6 strm cleared", s_to, 1'b0);
      check("R6 mem cleared", m_to, 1'b0);
      edges(40);
      check("R6 strm no expiry", s_to, 1'b0);
      check("R6 mem no expiry", m_to, 1'b0);

      // R9 disabled
      prep(12'd0, 1'b1, 1'b1);
      en = 1'b0;
      edges(40);
      check("R9 strm disabled", s_to, 1'b0);
      check("R9 mem disabled", m_to, 1'b0);

      // R3 restart on backpressure removal
      prep(12'd2, 1'b1, 1'b0);
      edges(8);
      ready = 1'b1;
      edges(1);
      ready = 1'b0;
      edges(10);
      check("R3 strm restarted", s_to, 1'b0);
      edges(1);
      check("R3 strm late expiry", s_to, 1'b1);

      // R4 restart on last beat
      prep(12'd2, 1'b0, 1'b1);
      edges(8);
      last = 1'b1;
      edges(1);
      last = 1'b0;
      edges(10);
      check("R4 mem restarted", m_to, 1'b0);
      edges(1);
      check("R4 mem late expiry", m_to, 1'b1);

      // R8 pause stream only
      prep(12'd2, 1'b1, 1'b1);
      hs = 1'b1;
      edges(4);
      hs = 1'b0;
      edges(8);
      check("R8 mem unaffected", m_to, 1'b1);
      check("R8 strm frozen", s_to, 1'b0);
      edges(4);
      check("R8 strm resumes", s_to, 1'b1);

      // R8 pause memory only
      prep(12'd0, 1'b1, 1'b1);
      hm = 1'b1;
      edges(8);
      check("R8 strm unaffected", s_to, 1'b1);
      check("R8 mem frozen", m_to, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule